// File: doc/BRIEF.md
# Triggered sample capture controller

This block records a run of 8-bit channel samples into an internal 1024-entry memory and later hands the run back to a host, one byte per read access. Each pulse of the sample tick latches the channel inputs. The latched byte is stored on the following clock, provided the trigger unit's armed signal and the software start bit are both high. Capture stops after exactly 1024 stored samples and the done flag goes high.

One 12-bit address counter serves both capture and readback. A bus-owner bit decides which side uses the memory. While the host owns it, capture is blocked and the read port shows the byte at the current address. The host read strobe may arrive from another timing domain, so it is synchronised first. Its trailing (falling) edge moves the counter to the next location. To read a full run, the host pulses the clear control and then performs 1024 reads.

Top module: `trig_capture`

## Requirements
- R1: After rst_n is low, done is 0 and both the address counter and the sample count are 0.
- R2: A sample tick latches chan_in. If that tick is accepted, the latched byte is written on the next clock into memory location addr[9:0], and the address then advances by one.
- R3: A tick is accepted only when trip=1, start=1, host_own=0 and done=0. Any other tick stores nothing and leaves the address and the count unchanged.
- R4: done goes high once exactly 1024 ticks have been accepted. It stays high until a clear, and later ticks store nothing.
- R5: clr=1 sets the address and the sample count to 0 on the next clock. It overrides a pending write and any capture or read advance in the same cycle.
- R6: With host_own=1, rd_data shows the memory byte at addr[9:0]. With host_own=0, rd_data is 0.
- R7: While host_own=1, the address advances by one on the third clock edge after rd_strobe falls, because of two synchroniser stages and one edge-detect stage. A rising edge of rd_strobe has no effect.
- R8: Only the low 10 bits of the 12-bit address select memory. The 1025th read after a clear therefore returns sample 0 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| samp_tick | input | 1 | One-cycle sample strobe |
| chan_in | input | 8 | Channel inputs |
| trip | input | 1 | Armed signal from the trigger unit |
| start | input | 1 | Software sampling enable |
| clr | input | 1 | Clears the address and the sample count |
| host_own | input | 1 | Memory owner: 0 = capture, 1 = host |
| rd_strobe | input | 1 | Host read strobe (asynchronous) |
| done | output | 1 | High when the capture is complete |
| rd_data | output | 8 | Byte at the current address while the host owns the memory |

## Verification
An address counter that is off by one appears at rd_data on the very next host-owned cycle, as a byte that belongs to the neighbouring sample. A miscounting sample count appears on done within one clock of the 1024th accepted tick. A gating fault, such as a write while the host owns the memory or a stored sample after done, stays hidden until readback returns a wrong byte at that location. The bench therefore compares every location, the wraparound reads and the done flag on every clock.

// File: rtl/trig_capture.sv
module trig_capture #(
  parameter int DW     = 8,
  parameter int MEM_AW = 10,
  parameter int CNT_W  = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          samp_tick,
  input  logic [DW-1:0] chan_in,
  input  logic          trip,
  input  logic          start,
  input  logic          clr,
  input  logic          host_own,
  input  logic          rd_strobe,
  output logic          done,
  output logic [DW-1:0] rd_data
);
  localparam int NSAMP = 1 << MEM_AW;
  localparam int SC_W  = MEM_AW + 1;

  logic [DW-1:0]    mem [NSAMP];
  logic [DW-1:0]    in_q;
  logic [CNT_W-1:0] addr;
  logic [SC_W-1:0]  cnt;
  logic             wr_pend;
  logic [2:0]       rs;
  logic             accept, rd_fall;

  assign done    = cnt[MEM_AW];
  assign accept  = samp_tick & trip & start & ~host_own & ~done;
  assign rd_fall = rs[2] & ~rs[1];
  assign rd_data = host_own ? mem[addr[MEM_AW-1:0]] : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rs <= '0;
    else        rs <= {rs[1:0], rd_strobe};

  always_ff @(posedge clk)
    if (samp_tick) in_q <= chan_in;

  always_ff @(posedge clk)
    if (wr_pend && !clr) mem[addr[MEM_AW-1:0]] <= in_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      addr    <= '0;
      cnt     <= '0;
      wr_pend <= 1'b0;
    end else if (clr) begin
      addr    <= '0;
      cnt     <= '0;
      wr_pend <= 1'b0;
    end else begin
      addr    <= addr + CNT_W'(wr_pend) + CNT_W'(rd_fall & host_own);
      cnt     <= cnt + SC_W'(accept);
      wr_pend <= accept;
    end
endmodule

module trig_capture_chk #(
  parameter int MEM_AW = 10,
  parameter int CNT_W  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clr,
  input logic              done,
  input logic              host_own,
  input logic              wr_pend,
  input logic [CNT_W-1:0]  addr,
  input logic [MEM_AW:0]   cnt
);
  a_r4_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    done && !clr |=> done);
  a_r4_no_count_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done && !clr |=> $stable(cnt));
  a_r5_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (addr == '0 && cnt == '0 && !wr_pend));
  a_r3_host_blocks_capture: assert property (@(posedge clk) disable iff (!rst_n)
    host_own |=> !wr_pend);
  a_r4_count_capped: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= (MEM_AW+1)'(1 << MEM_AW));
endmodule

bind trig_capture trig_capture_chk #(.MEM_AW(MEM_AW), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .done(done), .host_own(host_own),
  .wr_pend(wr_pend), .addr(addr), .cnt(cnt)
);

// File: tb/trig_capture_bench.sv
module trig_capture_bench;
  logic clk = 0, rst_n = 0, samp_tick = 0, trip = 0, start = 0;
  logic clr = 0, host_own = 0, rd_strobe = 0;
  logic [7:0] chan_in = 0;
  logic done;
  logic [7:0] rd_data;
  int checks = 0, failures = 0, cycle = 0;

  trig_capture u_trig_capture (.*);

  always #4 clk = ~clk;

  int m_mem [1024];
  bit m_valid [1024];
  int m_addr = 0, m_cnt = 0, m_inq = 0;
  bit m_pend = 0, sh1 = 0, sh2 = 0, sh3 = 0;

  function automatic int f(int i);
    return (i * 37 + 11) & 255;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cycle);
    end
  endtask

  always @(posedge clk) begin
    bit fall;
    cycle++;
    if (!rst_n) begin
      m_addr = 0; m_cnt = 0; m_pend = 0; sh1 = 0; sh2 = 0; sh3 = 0;
    end else begin
      fall = sh3 && !sh2;
      sh3 = sh2; sh2 = sh1; sh1 = rd_strobe;
      if (clr) begin
        m_addr = 0; m_cnt = 0; m_pend = 0;
      end else begin
        if (m_pend) begin
          m_mem[m_addr % 1024] = m_inq;
          m_valid[m_addr % 1024] = 1;
          m_addr = m_addr + 1;
        end
        if (fall && host_own) m_addr = m_addr + 1;
        m_addr = m_addr % 4096;
        m_pend = samp_tick && trip && start && !host_own && m_cnt < 1024;
        if (m_pend) m_cnt++;
      end
      if (samp_tick) m_inq = chan_in;
    end
    #2;
    if (rst_n) begin
      check("R4 done vs model", done, m_cnt == 1024);
      if (!host_own) check("R6 idle read", rd_data, 0);
      else if (m_valid[m_addr % 1024])
        check("R2/R7/R8 read byte", rd_data, m_mem[m_addr % 1024]);
    end
    if (cycle > 150000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic tick(int d);
    @(negedge clk); chan_in = d[7:0]; samp_tick = 1;
    @(negedge clk); samp_tick = 0;
  endtask

  task automatic do_clr;
    @(negedge clk); clr = 1;
    @(negedge clk); clr = 0;
  endtask

  task automatic host_read;
    @(negedge clk); rd_strobe = 1;
    repeat (2) @(negedge clk);
    rd_strobe = 0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset done", done, 0);
    start = 1;
    repeat (4) tick(8'h55);
    trip = 1; start = 0;
    repeat (4) tick(8'h55);
    start = 1; host_own = 1;
    repeat (4) tick(8'h55);
    host_own = 0;
    for (int i = 0; i < 5; i++) tick(8'hA1 + i);
    @(negedge clk);
    check("R6 idle rd_data zero", rd_data, 0);
    host_own = 1;
    do_clr;
    check("R3 first stored byte is first accepted", rd_data, 8'hA1);
    host_read;
    check("R7 second byte after read", rd_data, 8'hA2);
    host_own = 0;
    do_clr;
    for (int i = 0; i < 1030; i++) begin
      if (i % 3 == 0) begin
        @(negedge clk); chan_in = f(i); samp_tick = 1;
      end else tick(f(i));
    end
    @(negedge clk); samp_tick = 0;
    @(negedge clk);
    check("R4 done after 1024", done, 1);
    host_own = 1;
    do_clr;
    check("R5 clear keeps done low", done, 0);
    for (int k = 0; k < 1026; k++) begin
      if (k == 0 || k == 1 || k == 511 || k == 1023)
        check("R7 readback order", rd_data, f(k));
      if (k == 1024 || k == 1025)
        check("R8 address wraps memory", rd_data, f(k - 1024));
      host_read;
    end
    do_clr;
    check("R5 clear returns to sample 0", rd_data, f(0));
    @(negedge clk); rd_strobe = 1;
    repeat (6) @(negedge clk);
    check("R7 rising edge does not advance", rd_data, f(0));
    rd_strobe = 0;
    repeat (2) @(negedge clk);
    check("R7 no advance before third edge", rd_data, f(0));
    @(negedge clk);
    check("R7 advance on third edge", rd_data, f(1));
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule